// File: doc/BRIEF.md
# System Register Write Trap Resolver

This block decides what happens when software writes the register that raises software-generated interrupts. It takes a request strobe and a snapshot of the privilege context. That context covers:

- the current exception level;
- the per-level interface-enable bits for levels 1, 2 and 3;
- the state of the hypervisor level: whether it is enabled, whether it runs in 64-bit state, and its three trap controls;
- the state of the monitor (highest) level: whether it is present, whether it runs in 64-bit state, its IRQ and FIQ routing bits, and its non-secure control bit.

One cycle after the strobe, the block presents exactly one outcome. The outcome is one of: undefined instruction, trap to level 1, trap to level 2, trap to level 3, or write accepted. A trap outcome comes with the fixed syndrome code. An accepted write comes with a flag that says whether it counts as a secure access.

The checks for each exception level form a fixed priority chain, and the first condition that matches decides the outcome. The hypervisor conditions count only when the hypervisor level is both enabled and in 64-bit state. The monitor routing condition counts only when the monitor level is present, is in 64-bit state, and has both its IRQ and FIQ routing bits set. The block does not hold the register contents and does not enter the exception; both are left to the surrounding logic.

Top module: `sra_trap_resolver`

## Requirements
- R1: While reset is high and in the first cycle after it, res_vld, res_outcome, res_syndrome and res_secure are all 0.
- R2: res_vld is 1 in exactly the cycle after a cycle with req_vld high. Otherwise it is 0. When it is 1, res_outcome has exactly one bit set: bit0 undefined, bit1 trap to level 1, bit2 trap to level 2, bit3 trap to level 3, bit4 accepted.
- R3: A request with req_el = 0 gives the undefined outcome, whatever the other inputs are.
- R4: With req_el = 1, the first matching condition decides the outcome. The order is: ifc_en_l1 low gives trap to level 1; then hypervisor live with hyp_trap_all gives trap to level 2; then hypervisor live with hyp_fiq_rt gives trap to level 2; then hypervisor live with hyp_irq_rt gives trap to level 2; then monitor routing gives trap to level 3. If none matches, the write is accepted.
- R5: The hypervisor counts as live only when hyp_on and hyp_aa64 are both 1. The monitor routing condition holds only when mon_present, mon_aa64, mon_irq_rt and mon_fiq_rt are all 1.
- R6: With req_el = 2, the order is: ifc_en_l2 low gives trap to level 2; then monitor routing gives trap to level 3. If neither matches, the write is accepted. The hypervisor trap controls have no effect at this level.
- R7: With req_el = 3, ifc_en_l3 low gives trap to level 3. Otherwise the write is accepted.
- R8: res_syndrome is 0x18 whenever the outcome is a trap, and 0 otherwise.
- R9: res_secure is 1 only for an accepted write, and only when req_el is 3 or mon_ns is 0. At level 3, mon_ns has no effect on this flag.
- R10: In a cycle after one with req_vld low, res_outcome, res_syndrome and res_secure keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Write request strobe |
| req_el | input | 2 | Exception level of the writer |
| ifc_en_l1 | input | 1 | Register interface enabled for level 1 |
| ifc_en_l2 | input | 1 | Register interface enabled for level 2 |
| ifc_en_l3 | input | 1 | Register interface enabled for level 3 |
| hyp_on | input | 1 | Hypervisor level enabled |
| hyp_aa64 | input | 1 | Hypervisor level in 64-bit state |
| hyp_trap_all | input | 1 | Hypervisor common interrupt-register trap |
| hyp_fiq_rt | input | 1 | Hypervisor FIQ routing |
| hyp_irq_rt | input | 1 | Hypervisor IRQ routing |
| mon_present | input | 1 | Monitor level implemented |
| mon_aa64 | input | 1 | Monitor level in 64-bit state |
| mon_irq_rt | input | 1 | Monitor IRQ routing |
| mon_fiq_rt | input | 1 | Monitor FIQ routing |
| mon_ns | input | 1 | Monitor non-secure control bit |
| res_vld | output | 1 | Outcome valid, one cycle after the strobe |
| res_outcome | output | 5 | One-hot outcome |
| res_syndrome | output | 6 | Syndrome code for a trap |
| res_secure | output | 1 | Accepted write counts as secure |

## Verification
For every exception level, the bench applies all 8192 combinations of the thirteen control inputs. This sweep tells apart each step of the priority chains, including cases where several trap conditions hold at once and only the first one may win. It also shows that a hypervisor or monitor condition with only some of its qualifiers set does not trap. Random requests with gaps between them tell a held outcome apart from a freshly computed one. Directed cases at level 3 with mon_ns set tell the secure override apart from the plain non-secure rule.

// File: rtl/sra_pkg.sv
package sra_pkg;

    localparam int OC_N    = 5;
    localparam int OC_UNDEF_B = 0;
    localparam int OC_TRAP1_B = 1;
    localparam int OC_TRAP2_B = 2;
    localparam int OC_TRAP3_B = 3;
    localparam int OC_ACC_B   = 4;

    typedef logic [OC_N-1:0] outcome_t;

    localparam outcome_t OC_UNDEF  = outcome_t'(1) << OC_UNDEF_B;
    localparam outcome_t OC_TRAP1  = outcome_t'(1) << OC_TRAP1_B;
    localparam outcome_t OC_TRAP2  = outcome_t'(1) << OC_TRAP2_B;
    localparam outcome_t OC_TRAP3  = outcome_t'(1) << OC_TRAP3_B;
    localparam outcome_t OC_ACCEPT = outcome_t'(1) << OC_ACC_B;

    typedef enum logic [1:0] {
        LV_USER = 2'd0,
        LV_KERN = 2'd1,
        LV_HYP  = 2'd2,
        LV_MON  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic ifc_l1;
        logic ifc_l2;
        logic ifc_l3;
        logic hyp_on;
        logic hyp_aa64;
        logic hyp_trap_all;
        logic hyp_fiq_rt;
        logic hyp_irq_rt;
        logic mon_present;
        logic mon_aa64;
        logic mon_irq_rt;
        logic mon_fiq_rt;
    } ctrl_t;

    typedef struct packed {
        logic l1_off;
        logic l2_off;
        logic l3_off;
        logic hyp_all_hit;
        logic hyp_fiq_hit;
        logic hyp_irq_hit;
        logic mon_hit;
    } cond_t;

    function automatic logic is_trap(input outcome_t oc);
        return oc[OC_TRAP1_B] | oc[OC_TRAP2_B] | oc[OC_TRAP3_B];
    endfunction

endpackage

// File: rtl/sra_cond.sv
module sra_cond
    import sra_pkg::*;
(
    input  ctrl_t ctrl,
    output cond_t cond
);
    logic hyp_live;
    logic mon_live;

    always_comb begin
        hyp_live = ctrl.hyp_on & ctrl.hyp_aa64;
        mon_live = ctrl.mon_present & ctrl.mon_aa64;

        cond.l1_off      = ~ctrl.ifc_l1;
        cond.l2_off      = ~ctrl.ifc_l2;
        cond.l3_off      = ~ctrl.ifc_l3;
        cond.hyp_all_hit = hyp_live & ctrl.hyp_trap_all;
        cond.hyp_fiq_hit = hyp_live & ctrl.hyp_fiq_rt;
        cond.hyp_irq_hit = hyp_live & ctrl.hyp_irq_rt;
        cond.mon_hit     = mon_live & ctrl.mon_irq_rt & ctrl.mon_fiq_rt;
    end
endmodule

// File: rtl/sra_prio.sv
module sra_prio
    import sra_pkg::*;
(
    input  lvl_e     lvl,
    input  cond_t    cond,
    output outcome_t oc
);
    always_comb begin
        oc = OC_ACCEPT;
        unique case (lvl)
            LV_USER: oc = OC_UNDEF;
            LV_KERN: begin
                if (cond.l1_off)           oc = OC_TRAP1;
                else if (cond.hyp_all_hit) oc = OC_TRAP2;
                else if (cond.hyp_fiq_hit) oc = OC_TRAP2;
                else if (cond.hyp_irq_hit) oc = OC_TRAP2;
                else if (cond.mon_hit)     oc = OC_TRAP3;
                else                       oc = OC_ACCEPT;
            end
            LV_HYP: begin
                if (cond.l2_off)           oc = OC_TRAP2;
                else if (cond.mon_hit)     oc = OC_TRAP3;
                else                       oc = OC_ACCEPT;
            end
            LV_MON: begin
                if (cond.l3_off)           oc = OC_TRAP3;
                else                       oc = OC_ACCEPT;
            end
            default: oc = OC_UNDEF;
        endcase
    end
endmodule

// File: rtl/sra_out_reg.sv
module sra_out_reg
    import sra_pkg::*;
#(
    parameter int                SYND_W    = 6,
    parameter logic [SYND_W-1:0] SYND_CODE = 6'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  outcome_t          oc_in,
    input  logic              sec_in,
    output logic              vld_q,
    output outcome_t          oc_q,
    output logic [SYND_W-1:0] synd_q,
    output logic              sec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            oc_q   <= '0;
            synd_q <= '0;
            sec_q  <= 1'b0;
        end else begin
            vld_q <= req_vld;
            if (req_vld) begin
                oc_q   <= oc_in;
                synd_q <= is_trap(oc_in) ? SYND_CODE : '0;
                sec_q  <= sec_in;
            end
        end
    end
endmodule

// File: rtl/sra_trap_resolver.sv
module sra_trap_resolver
    import sra_pkg::*;
#(
    parameter int                SYND_W    = 6,
    parameter logic [SYND_W-1:0] SYND_CODE = 6'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [1:0]        req_el,
    input  logic              ifc_en_l1,
    input  logic              ifc_en_l2,
    input  logic              ifc_en_l3,
    input  logic              hyp_on,
    input  logic              hyp_aa64,
    input  logic              hyp_trap_all,
    input  logic              hyp_fiq_rt,
    input  logic              hyp_irq_rt,
    input  logic              mon_present,
    input  logic              mon_aa64,
    input  logic              mon_irq_rt,
    input  logic              mon_fiq_rt,
    input  logic              mon_ns,
    output logic              res_vld,
    output logic [OC_N-1:0]   res_outcome,
    output logic [SYND_W-1:0] res_syndrome,
    output logic              res_secure
);
    ctrl_t    ctrl;
    cond_t    cond;
    lvl_e     lvl;
    outcome_t oc_sel;
    logic     sec_sel;

    always_comb begin
        lvl                = lvl_e'(req_el);
        ctrl.ifc_l1        = ifc_en_l1;
        ctrl.ifc_l2        = ifc_en_l2;
        ctrl.ifc_l3        = ifc_en_l3;
        ctrl.hyp_on        = hyp_on;
        ctrl.hyp_aa64      = hyp_aa64;
        ctrl.hyp_trap_all  = hyp_trap_all;
        ctrl.hyp_fiq_rt    = hyp_fiq_rt;
        ctrl.hyp_irq_rt    = hyp_irq_rt;
        ctrl.mon_present   = mon_present;
        ctrl.mon_aa64      = mon_aa64;
        ctrl.mon_irq_rt    = mon_irq_rt;
        ctrl.mon_fiq_rt    = mon_fiq_rt;
    end

    sra_cond i_cond (
        .ctrl (ctrl),
        .cond (cond)
    );

    sra_prio i_prio (
        .lvl  (lvl),
        .cond (cond),
        .oc   (oc_sel)
    );

    // Monitor-level accesses are secure regardless of the non-secure bit.
    always_comb begin
        sec_sel = oc_sel[OC_ACC_B] & ((lvl == LV_MON) | ~mon_ns);
    end

    sra_out_reg #(
        .SYND_W    (SYND_W),
        .SYND_CODE (SYND_CODE)
    ) i_out (
        .clk     (clk),
        .rst     (rst),
        .req_vld (req_vld),
        .oc_in   (oc_sel),
        .sec_in  (sec_sel),
        .vld_q   (res_vld),
        .oc_q    (res_outcome),
        .synd_q  (res_syndrome),
        .sec_q   (res_secure)
    );
endmodule

// File: rtl/sra_trap_resolver_chk.sv
module sra_trap_resolver_chk #(
    parameter int SYND_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic [1:0]        req_el,
    input logic              ifc_en_l1,
    input logic              ifc_en_l3,
    input logic              res_vld,
    input logic [4:0]        res_outcome,
    input logic [SYND_W-1:0] res_syndrome,
    input logic              res_secure
);
    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> res_vld);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !res_vld);
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> ($countones(res_outcome) == 1));
    p_user_undef_r3: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_el == 2'd0) |=> (res_outcome == 5'b00001));
    p_kern_off_r4: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_el == 2'd1 && !ifc_en_l1) |=> (res_outcome == 5'b00010));
    p_mon_off_r7: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_el == 2'd3 && !ifc_en_l3) |=> (res_outcome == 5'b01000));
    p_synd_r8: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> ((res_syndrome != '0) == (res_outcome[3:1] != 3'b000)));
    p_mon_secure_r9: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_el == 2'd3) |=> (res_secure == res_outcome[4]));
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> ($stable(res_outcome) && $stable(res_syndrome) && $stable(res_secure)));
endmodule

bind sra_trap_resolver sra_trap_resolver_chk #(.SYND_W(SYND_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_vld      (req_vld),
    .req_el       (req_el),
    .ifc_en_l1    (ifc_en_l1),
    .ifc_en_l3    (ifc_en_l3),
    .res_vld      (res_vld),
    .res_outcome  (res_outcome),
    .res_syndrome (res_syndrome),
    .res_secure   (res_secure)
);

// File: tb/test_sra_trap_resolver.sv
`timescale 1ns/1ps
module test_sra_trap_resolver;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_vld;
    logic [1:0] req_el;
    logic [12:0] v;
    logic       res_vld;
    logic [4:0] res_outcome;
    logic [5:0] res_syndrome;
    logic       res_secure;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [4:0] last_oc;
    logic [5:0] last_sy;
    logic       last_sec;

    always #4 clk = ~clk;

    sra_trap_resolver i_sra_trap_resolver (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_el(req_el),
        .ifc_en_l1(v[0]), .ifc_en_l2(v[1]), .ifc_en_l3(v[2]),
        .hyp_on(v[3]), .hyp_aa64(v[4]), .hyp_trap_all(v[5]),
        .hyp_fiq_rt(v[6]), .hyp_irq_rt(v[7]),
        .mon_present(v[8]), .mon_aa64(v[9]), .mon_irq_rt(v[10]),
        .mon_fiq_rt(v[11]), .mon_ns(v[12]),
        .res_vld(res_vld), .res_outcome(res_outcome),
        .res_syndrome(res_syndrome), .res_secure(res_secure)
    );

    // Reference model written from the requirements.
    function automatic logic [4:0] model_oc(input logic [1:0] el, input logic [12:0] c);
        logic hyp, mon;
        hyp = c[3] && c[4];
        mon = c[8] && c[9] && c[10] && c[11];
        if (el == 0) return 5'b00001;
        if (el == 1) begin
            if (!c[0])        return 5'b00010;
            if (hyp && c[5])  return 5'b00100;
            if (hyp && c[6])  return 5'b00100;
            if (hyp && c[7])  return 5'b00100;
            if (mon)          return 5'b01000;
            return 5'b10000;
        end
        if (el == 2) begin
            if (!c[1]) return 5'b00100;
            if (mon)   return 5'b01000;
            return 5'b10000;
        end
        if (!c[2]) return 5'b01000;
        return 5'b10000;
    endfunction

    function automatic logic model_sec(input logic [1:0] el, input logic [12:0] c);
        return (model_oc(el, c) == 5'b10000) && (el == 3 || !c[12]);
    endfunction

    function automatic string lvl_tag(input logic [1:0] el);
        case (el)
            2'd0: return "R3";
            2'd1: return "R4/R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drives, then checks at the next negedge.
    task automatic apply(input logic rq, input logic [1:0] el, input logic [12:0] c);
        logic [4:0] e_oc;
        logic [5:0] e_sy;
        logic       e_sec;
        req_vld = rq; req_el = el; v = c;
        if (rq) begin
            e_oc  = model_oc(el, c);
            e_sy  = (e_oc[3:1] != 0) ? 6'h18 : 6'h00;
            e_sec = model_sec(el, c);
        end else begin
            e_oc = last_oc; e_sy = last_sy; e_sec = last_sec;
        end
        @(negedge clk);
        check(res_vld == rq, "R2 valid", res_vld, rq);
        if (rq) begin
            check(res_outcome == e_oc, lvl_tag(el), res_outcome, e_oc);
            check(res_syndrome == e_sy, "R8 syndrome", res_syndrome, e_sy);
            check(res_secure == e_sec, "R9 secure", res_secure, e_sec);
        end else begin
            check({res_outcome, res_syndrome, res_secure} == {e_oc, e_sy, e_sec},
                  "R10 hold", {res_outcome, res_syndrome, res_secure}, {e_oc, e_sy, e_sec});
        end
        last_oc = e_oc; last_sy = e_sy; last_sec = e_sec;
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; req_vld = 1'b0; req_el = 2'd0; v = '0;
        repeat (3) @(negedge clk);
        check({res_vld, res_outcome, res_syndrome, res_secure} == '0, "R1 reset in",
              {res_vld, res_outcome, res_syndrome, res_secure}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({res_vld, res_outcome, res_syndrome, res_secure} == '0, "R1 reset out",
              {res_vld, res_outcome, res_syndrome, res_secure}, 0);
        last_oc = '0; last_sy = '0; last_sec = 1'b0;

        // Directed corners: R9 override at level 3, R5 partial qualifiers, R6 ignores hyp traps.
        apply(1'b1, 2'd3, 13'h1004 | 13'h0007);
        apply(1'b1, 2'd2, 13'h0002 | 13'h00F8);
        apply(1'b1, 2'd1, 13'h0001 | 13'h00E8);
        apply(1'b1, 2'd1, 13'h0001 | 13'h0700);
        apply(1'b1, 2'd1, 13'h0001 | 13'h0F00);

        // Exhaustive sweep per level.
        for (int el = 0; el < 4; el++)
            for (int c = 0; c < 8192; c++)
                apply(1'b1, el[1:0], c[12:0]);

        // Random mix with idle gaps.
        for (int i = 0; i < 4000; i++)
            apply(($urandom % 3) != 0, 2'($urandom), 13'($urandom));

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule